// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block picks the handshake that a USB device's control endpoint sends back to the host, one transaction at a time. Each clock cycle it may receive one token event (SETUP, IN or OUT). It combines that event with the current control stage, the read or write direction of the transfer, and the buffer-ready flags from the serial interface engine side. The rest comes from a programmable 2-bit response code and a completion bit, which firmware writes. The result is a registered handshake: ACK, NAK, STALL, a data packet, or a zero-length packet.

Hardware events can rewrite the response code on their own. A SETUP token parks it at NAK, a control sequence error forces STALL, and an automatically answered request switches to buffer-controlled mode and sets the completion bit. The response code and completion bit are read back on output ports. A sticky buffer-not-ready flag records any data-stage token that found its buffer unavailable. Packet encoding, CRC, request decoding and stage tracking sit outside this block.

Top module: `ctl_hs_responder`

## Requirements
- R1: For each token (tok_kind 1 = SETUP, 2 = IN, 3 = OUT) the block raises hs_valid for exactly one cycle, on the cycle after the token. hs_code then carries 0 = ACK, 1 = NAK, 2 = STALL, 3 = DATA, 4 = ZLP. With tok_kind 0 (idle), hs_valid is 0 on the following cycle.
- R2: A SETUP token is answered with ACK whatever the response code, stage or completion bit hold.
- R3: For IN and OUT tokens, response code 00 gives NAK, and 10 or 11 gives STALL, in every stage.
- R4: A write to the response code (rc_wr) is discarded while valid_flag is 1. The rc_q readback keeps its old value.
- R5: A token uses the response code held before its own cycle. A write in the same cycle only affects later transactions, and rc_q shows the new value one cycle after the write.
- R6: With code 01 in the data stage (stage 1): under control write (dir_read 0), an OUT gets ACK if rx_ready, else NAK. Under control read (dir_read 1), an IN gets DATA if tx_ready, else NAK. A token opposite to the selected direction gets STALL. With code 01, IN or OUT in stage 0 or 3 gets NAK.
- R7: With code 01 in the status stage (stage 2), completion bit 0 gives NAK. Completion bit 1 gives ACK for OUT and ZLP for IN.
- R8: seq_err forces the response code to 10, and a SETUP token forces it to 00. The priority order is seq_err, then SETUP, then auto_req, then a software write.
- R9: auto_req sets the completion bit to 1, overriding a same-cycle completion write. Unless seq_err or a SETUP token occurs in the same cycle, it also sets the response code to 01.
- R10: nrdy_flag is set by every NAK of R6 caused by a missing buffer, and is visible on the cycle after the token. It stays set until a nrdy_clr strobe clears it. If a set and a clear happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_kind | input | 2 | Token event: 0 idle, 1 SETUP, 2 IN, 3 OUT |
| stage | input | 2 | Control stage: 0 setup, 1 data, 2 status |
| dir_read | input | 1 | 1 = control read, 0 = control write |
| rx_ready | input | 1 | Receive buffer ready |
| tx_ready | input | 1 | Transmit buffer ready |
| valid_flag | input | 1 | Locks software writes to the response code |
| rc_wr | input | 1 | Response code write strobe |
| rc_wdata | input | 2 | Response code write value |
| cmpl_wr | input | 1 | Completion bit write strobe |
| cmpl_wdata | input | 1 | Completion bit write value |
| nrdy_clr | input | 1 | Clear strobe for the buffer-not-ready flag |
| auto_req | input | 1 | Automatically answered request received |
| seq_err | input | 1 | Control sequence error strobe |
| hs_valid | output | 1 | Handshake decision present |
| hs_code | output | 3 | Handshake to send |
| rc_q | output | 2 | Current response code |
| cmpl_q | output | 1 | Current completion bit |
| nrdy_flag | output | 1 | Sticky buffer-not-ready flag |

## Verification
Random streams of tokens, stages, directions and buffer flags are run against all four response-code values. These streams separate the fixed NAK and STALL answers from the buffer-driven answers, and the data-stage answers from the status-stage answers. Software writes are mixed in at random, some while valid_flag is set, and the readback shows whether a locked write leaked through. Directed cases pair a write with a token in the same cycle, which shows whether the old or the new code was used. Other directed cases raise seq_err together with SETUP and a clear together with a set, which exposes the priority order. Finally, auto_req followed by a status IN must produce ZLP.

// File: rtl/ctl_hs_pkg.sv
package ctl_hs_pkg;
  localparam int TOK_W  = 2;
  localparam int STG_W  = 2;
  localparam int RC_W   = 2;
  localparam int HS_W   = 3;

  localparam logic [TOK_W-1:0] TK_IDLE  = 2'd0;
  localparam logic [TOK_W-1:0] TK_SETUP = 2'd1;
  localparam logic [TOK_W-1:0] TK_IN    = 2'd2;
  localparam logic [TOK_W-1:0] TK_OUT   = 2'd3;

  localparam logic [STG_W-1:0] SG_SETUP  = 2'd0;
  localparam logic [STG_W-1:0] SG_DATA   = 2'd1;
  localparam logic [STG_W-1:0] SG_STATUS = 2'd2;

  localparam logic [RC_W-1:0] RC_NAK   = 2'b00;
  localparam logic [RC_W-1:0] RC_BUF   = 2'b01;
  localparam logic [RC_W-1:0] RC_STALL = 2'b10;

  localparam logic [HS_W-1:0] HS_ACK   = 3'd0;
  localparam logic [HS_W-1:0] HS_NAK   = 3'd1;
  localparam logic [HS_W-1:0] HS_STALL = 3'd2;
  localparam logic [HS_W-1:0] HS_DATA  = 3'd3;
  localparam logic [HS_W-1:0] HS_ZLP   = 3'd4;
endpackage

// File: rtl/ctl_hs_regs.sv
module ctl_hs_regs
  import ctl_hs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            rc_wr,
  input  logic [RC_W-1:0] rc_wdata,
  input  logic            valid_flag,
  input  logic            cmpl_wr,
  input  logic            cmpl_wdata,
  input  logic            setup_seen,
  input  logic            seq_err,
  input  logic            auto_req,
  output logic [RC_W-1:0] rc_q,
  output logic            cmpl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rc_q   <= RC_NAK;
      cmpl_q <= 1'b0;
    end else begin
      if (seq_err)                  rc_q <= RC_STALL;
      else if (setup_seen)          rc_q <= RC_NAK;
      else if (auto_req)            rc_q <= RC_BUF;
      else if (rc_wr && !valid_flag) rc_q <= rc_wdata;

      if (auto_req)     cmpl_q <= 1'b1;
      else if (cmpl_wr) cmpl_q <= cmpl_wdata;
    end
  end
endmodule

// File: rtl/ctl_hs_decide.sv
module ctl_hs_decide
  import ctl_hs_pkg::*;
(
  input  logic [TOK_W-1:0] tok_kind,
  input  logic [STG_W-1:0] stage,
  input  logic             dir_read,
  input  logic             rx_ready,
  input  logic             tx_ready,
  input  logic [RC_W-1:0]  rc,
  input  logic             cmpl,
  output logic             fire,
  output logic [HS_W-1:0]  code,
  output logic             nrdy_set
);
  logic is_in;
  assign is_in = (tok_kind == TK_IN);

  always_comb begin
    fire     = (tok_kind != TK_IDLE);
    code     = HS_NAK;
    nrdy_set = 1'b0;
    if (tok_kind == TK_SETUP) begin
      code = HS_ACK;
    end else if (rc[1]) begin
      code = HS_STALL;
    end else if (rc == RC_NAK) begin
      code = HS_NAK;
    end else begin
      case (stage)
        SG_DATA: begin
          if (dir_read != is_in) begin
            code = HS_STALL;
          end else if (is_in) begin
            code     = tx_ready ? HS_DATA : HS_NAK;
            nrdy_set = !tx_ready;
          end else begin
            code     = rx_ready ? HS_ACK : HS_NAK;
            nrdy_set = !rx_ready;
          end
        end
        SG_STATUS: begin
          if (!cmpl)      code = HS_NAK;
          else if (is_in) code = HS_ZLP;
          else            code = HS_ACK;
        end
        default: code = HS_NAK;
      endcase
    end
    if (!fire) nrdy_set = 1'b0;
  end
endmodule

// File: rtl/ctl_hs_nrdy.sv
module ctl_hs_nrdy (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/ctl_hs_responder.sv
module ctl_hs_responder
  import ctl_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [TOK_W-1:0] tok_kind,
  input  logic [STG_W-1:0] stage,
  input  logic             dir_read,
  input  logic             rx_ready,
  input  logic             tx_ready,
  input  logic             valid_flag,
  input  logic             rc_wr,
  input  logic [RC_W-1:0]  rc_wdata,
  input  logic             cmpl_wr,
  input  logic             cmpl_wdata,
  input  logic             nrdy_clr,
  input  logic             auto_req,
  input  logic             seq_err,
  output logic             hs_valid,
  output logic [HS_W-1:0]  hs_code,
  output logic [RC_W-1:0]  rc_q,
  output logic             cmpl_q,
  output logic             nrdy_flag
);
  logic            d_fire;
  logic [HS_W-1:0] d_code;
  logic            d_nrdy;

  ctl_hs_regs u_regs (
    .clk(clk), .rst(rst), .rc_wr(rc_wr), .rc_wdata(rc_wdata),
    .valid_flag(valid_flag), .cmpl_wr(cmpl_wr), .cmpl_wdata(cmpl_wdata),
    .setup_seen(tok_kind == TK_SETUP), .seq_err(seq_err),
    .auto_req(auto_req), .rc_q(rc_q), .cmpl_q(cmpl_q)
  );

  ctl_hs_decide u_dec (
    .tok_kind(tok_kind), .stage(stage), .dir_read(dir_read),
    .rx_ready(rx_ready), .tx_ready(tx_ready), .rc(rc_q), .cmpl(cmpl_q),
    .fire(d_fire), .code(d_code), .nrdy_set(d_nrdy)
  );

  ctl_hs_nrdy u_nrdy (
    .clk(clk), .rst(rst), .set_i(d_nrdy), .clr_i(nrdy_clr), .flag_q(nrdy_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_ACK;
    end else begin
      hs_valid <= d_fire;
      hs_code  <= d_fire ? d_code : HS_ACK;
    end
  end
endmodule

// File: rtl/ctl_hs_checker.sv
module ctl_hs_checker
  import ctl_hs_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [TOK_W-1:0] tok_kind,
  input logic             valid_flag,
  input logic             rc_wr,
  input logic             auto_req,
  input logic             seq_err,
  input logic             nrdy_clr,
  input logic             hs_valid,
  input logic [HS_W-1:0]  hs_code,
  input logic [RC_W-1:0]  rc_q,
  input logic             cmpl_q,
  input logic             nrdy_flag
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (tok_kind == TK_IDLE) |=> !hs_valid); // R1
  AST_SETUP_ACK: assert property (@(posedge clk) disable iff (rst)
    (tok_kind == TK_SETUP) |=> (hs_valid && hs_code == HS_ACK)); // R2
  AST_WRITE_LOCK: assert property (@(posedge clk) disable iff (rst)
    (valid_flag && rc_wr && !seq_err && !auto_req && tok_kind != TK_SETUP) |=> $stable(rc_q)); // R4
  AST_SEQ_STALL: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> (rc_q == RC_STALL)); // R8
  AST_AUTO_CMPL: assert property (@(posedge clk) disable iff (rst)
    auto_req |=> cmpl_q); // R9
  AST_NRDY_STICKY: assert property (@(posedge clk) disable iff (rst)
    (nrdy_flag && !nrdy_clr) |=> nrdy_flag); // R10
endmodule

bind ctl_hs_responder ctl_hs_checker u_chk (
  .clk(clk), .rst(rst), .tok_kind(tok_kind), .valid_flag(valid_flag),
  .rc_wr(rc_wr), .auto_req(auto_req), .seq_err(seq_err), .nrdy_clr(nrdy_clr),
  .hs_valid(hs_valid), .hs_code(hs_code), .rc_q(rc_q), .cmpl_q(cmpl_q),
  .nrdy_flag(nrdy_flag)
);

// File: tb/sim_ctl_hs_responder.sv
module sim_ctl_hs_responder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] tok_kind = 0, stage = 0, rc_wdata = 0;
  logic dir_read = 0, rx_ready = 0, tx_ready = 0, valid_flag = 0, rc_wr = 0;
  logic cmpl_wr = 0, cmpl_wdata = 0, nrdy_clr = 0, auto_req = 0, seq_err = 0;
  logic hs_valid, cmpl_q, nrdy_flag;
  logic [2:0] hs_code;
  logic [1:0] rc_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [1:0] m_rc;
  logic m_cmpl, m_nrdy;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_hs_responder u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_in();
    tok_kind = 0; rc_wr = 0; cmpl_wr = 0; nrdy_clr = 0; auto_req = 0; seq_err = 0;
  endtask

  // Expected handshake: {fire, code[2:0], nrdy_set}
  function automatic logic [4:0] ref_hs(input logic [1:0] tk, input logic [1:0] sg,
                                        input logic rd, input logic rx, input logic tx,
                                        input logic [1:0] rc, input logic cp);
    if (tk == 2'd0) return 5'b0_000_0;
    if (tk == 2'd1) return {1'b1, 3'd0, 1'b0};
    if (rc[1]) return {1'b1, 3'd2, 1'b0};
    if (rc == 2'b00) return {1'b1, 3'd1, 1'b0};
    if (sg == 2'd1) begin
      if (rd != (tk == 2'd2)) return {1'b1, 3'd2, 1'b0};
      if (tk == 2'd2) return tx ? {1'b1, 3'd3, 1'b0} : {1'b1, 3'd1, 1'b1};
      return rx ? {1'b1, 3'd0, 1'b0} : {1'b1, 3'd1, 1'b1};
    end
    if (sg == 2'd2) begin
      if (!cp) return {1'b1, 3'd1, 1'b0};
      return (tk == 2'd2) ? {1'b1, 3'd4, 1'b0} : {1'b1, 3'd0, 1'b0};
    end
    return {1'b1, 3'd1, 1'b0};
  endfunction

  function automatic string hs_tag(input logic [1:0] tk, input logic [1:0] sg, input logic [1:0] rc);
    if (tk == 2'd0) return "R1";
    if (tk == 2'd1) return "R2";
    if (rc != 2'b01) return "R3";
    if (sg == 2'd2) return "R7";
    return "R6";
  endfunction

  task automatic step();
    logic [4:0] e;
    logic [1:0] nrc;
    logic ncp, nnr;
    string t;
    e = ref_hs(tok_kind, stage, dir_read, rx_ready, tx_ready, m_rc, m_cmpl);
    t = hs_tag(tok_kind, stage, m_rc);
    nrc = m_rc;
    if (seq_err) nrc = 2'b10;
    else if (tok_kind == 2'd1) nrc = 2'b00;
    else if (auto_req) nrc = 2'b01;
    else if (rc_wr && !valid_flag) nrc = rc_wdata;
    ncp = auto_req ? 1'b1 : (cmpl_wr ? cmpl_wdata : m_cmpl);
    nnr = e[0] ? 1'b1 : (nrdy_clr ? 1'b0 : m_nrdy);
    @(posedge clk); #1;
    m_rc = nrc; m_cmpl = ncp; m_nrdy = nnr;
    chk({"R1 hs_valid/", t}, int'(hs_valid), int'(e[4]));
    if (e[4]) chk({t, " hs_code"}, int'(hs_code), int'(e[3:1]));
    chk("R8/R4/R5 rc_q", int'(rc_q), int'(m_rc));
    chk("R9 cmpl_q", int'(cmpl_q), int'(m_cmpl));
    chk("R10 nrdy_flag", int'(nrdy_flag), int'(m_nrdy));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_rc = 0; m_cmpl = 0; m_nrdy = 0;
    idle_in();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R1 reset hs_valid", int'(hs_valid), 0);
    chk("R8 reset rc_q", int'(rc_q), 0);
    chk("R10 reset nrdy", int'(nrdy_flag), 0);

    // R4: locked write is discarded
    valid_flag = 1; rc_wr = 1; rc_wdata = 2'b01; step(); idle_in();
    chk("R4 locked write rc_q", int'(rc_q), 0);
    // R5: write with same-cycle data OUT uses old code (NAK)
    valid_flag = 0; rc_wr = 1; rc_wdata = 2'b01; tok_kind = 3; stage = 1;
    dir_read = 0; rx_ready = 1; step(); idle_in();
    chk("R5 old code used", int'(hs_code), 1);
    chk("R5 new code visible", int'(rc_q), 1);
    // R6: control write, not ready -> NAK + flag
    tok_kind = 3; stage = 1; rx_ready = 0; step(); idle_in();
    // R10: set and clear same cycle -> stays set
    tok_kind = 3; nrdy_clr = 1; step(); idle_in();
    chk("R10 set wins", int'(nrdy_flag), 1);
    nrdy_clr = 1; step(); idle_in();
    chk("R10 cleared", int'(nrdy_flag), 0);
    // R8: seq_err with SETUP -> STALL; SETUP still ACKed
    seq_err = 1; tok_kind = 1; step(); idle_in();
    chk("R8 seq_err over setup", int'(rc_q), 2);
    // R9: auto request then status IN -> ZLP
    auto_req = 1; cmpl_wr = 1; cmpl_wdata = 0; step(); idle_in();
    tok_kind = 2; stage = 2; step(); idle_in();
    chk("R9 status IN ZLP", int'(hs_code), 4);

    for (int i = 0; i < 3000; i++) begin
      int r;
      idle_in();
      tok_kind   = 2'($urandom_range(0, 3));
      stage      = 2'($urandom_range(0, 3));
      dir_read   = 1'($urandom);
      rx_ready   = 1'($urandom);
      tx_ready   = 1'($urandom);
      valid_flag = ($urandom_range(0, 3) == 0);
      r = $urandom_range(0, 99);
      rc_wr      = (r < 30);
      rc_wdata   = 2'($urandom_range(0, 3));
      cmpl_wr    = ($urandom_range(0, 9) == 0);
      cmpl_wdata = 1'($urandom);
      nrdy_clr   = ($urandom_range(0, 7) == 0);
      auto_req   = ($urandom_range(0, 29) == 0);
      seq_err    = ($urandom_range(0, 49) == 0);
      if (tok_kind == 2'd1 && $urandom_range(0, 1) == 0) tok_kind = 2'd2;
      step();
    end
    idle_in();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule